// File: doc/BRIEF.md
# Transaction Abort Backoff Sequencer

This block decides what a core does after its hardware transaction fails. When the transaction cache reports an abort while a transaction is running, the block first drives a word-by-word restore handshake. The handshake brings the architectural registers back from a register scratchpad that is 32 words of 32 bits. Once the last word is acknowledged, the block raises a low-power enable and holds the core asleep for a pseudo-random number of cycles. It then wakes the core and signals that the transaction may be retried.

The sleep length is drawn from a 16-bit linear feedback shift register. It is masked to a window whose width doubles with every consecutive abort, up to 1024 cycles, so that cores that keep colliding spread out further on each attempt. A commit clears the consecutive-abort count, and with it the window. The count is exposed as a 4-bit output for software to read. Only the handshake is modelled here: the scratchpad data and the transaction cache sit outside the block.

Top module: `txBackoffTop`

## Requirements
- R1: While `rstN` is low and in the first cycle after reset, `restoreReq`, `lowPowerEn`, `wakePulse` and `retryStart` are 0, and `abortCount` and `restoreIdx` are 0.
- R2: `txBegin` while idle starts a transaction without a `retryStart` pulse. `txAbort` during a running transaction raises `restoreReq` on the next cycle, with `restoreIdx` = 0 and `lowPowerEn` = 0.
- R3: The restore walks word indices 0 to 31 in order. `restoreIdx` advances only in a cycle where `restoreAck` is 1, and holds while `restoreAck` is 0.
- R4: In the cycle after the acknowledge of word 31, `restoreReq` drops and `lowPowerEn` rises. `lowPowerEn` stays high for exactly delay+1 cycles and is never high together with `restoreReq`.
- R5: The random source is a 16-bit shift register with seed 0xACE1. Each accepted abort shifts it left by one, inserting bit15^bit13^bit12^bit10 at bit 0. The delay uses the register value after that shift.
- R6: delay = (register bits [9:0]) AND (2^e − 1), where e = min(abortCount, 10) and abortCount is the value after the current abort is counted.
- R7: When the sleep ends, `wakePulse` is high for one cycle with `lowPowerEn` low. `retryStart` is high for one cycle in the cycle right after it, and the transaction is then running again.
- R8: `txAbort` has no effect while idle, while restoring, while asleep or in the wake cycle. It does not change `abortCount`, restart the restore, or alter the sleep length.
- R9: `abortCount` goes up by one on each accepted abort and saturates at 15.
- R10: `txCommit` during a running transaction clears `abortCount` to 0 and returns to idle. The next abort uses e = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txBegin | input | 1 | Transaction begin event |
| txCommit | input | 1 | Transaction commit event |
| txAbort | input | 1 | Transaction abort event |
| restoreAck | input | 1 | Scratchpad has restored the word at `restoreIdx` |
| restoreReq | output | 1 | Restore of word `restoreIdx` requested |
| restoreIdx | output | 5 | Index of the scratchpad word being restored |
| lowPowerEn | output | 1 | Core held in low-power sleep |
| wakePulse | output | 1 | One-cycle wake indication |
| retryStart | output | 1 | One-cycle retry start, the cycle after `wakePulse` |
| abortCount | output | 4 | Consecutive abort count, saturating |

## Verification
Some rules are checked by the assertions on every cycle:
- `restoreReq` and `lowPowerEn` are never high together.
- The restore index starts at zero and holds on a stalled acknowledge.
- A wake is followed by exactly one retry.
- A saturated count stays saturated, and aborts during sleep leave the count alone.

Other behaviour shows only through the bench's scenarios, which run a separate model of the shift register and the window. These are the exact sleep length for each abort, the growth of the window and its cap at 1024 cycles, and the return to the smallest window after a commit.

// File: rtl/txBackoffPkg.sv
package txBackoffPkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RESTORE = 3'd1,
    ST_SLEEP   = 3'd2,
    ST_WAKE    = 3'd3,
    ST_RUN     = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic abortTake;    // count the abort, step the random source, clear index
    logic commitTake;   // clear the consecutive-abort count
    logic restoreStep;  // advance the restore word index
    logic sleepLoad;    // load the sleep counter from the masked random value
    logic sleepDec;     // count the sleep down
  } pathCtl_t;

endpackage

// File: rtl/txBackoffCtrl.sv
module txBackoffCtrl
  import txBackoffPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     txBegin,
  input  logic     txCommit,
  input  logic     txAbort,
  input  logic     restoreAck,
  input  logic     idxLast,
  input  logic     sleepZero,
  output pathCtl_t ctl,
  output logic     restoreReq,
  output logic     lowPowerEn,
  output logic     wakePulse,
  output logic     retryStart
);

  seqState_t stateQ, stateD;
  logic      retryQ;

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (txBegin) stateD = ST_RUN;
      end
      ST_RUN: begin
        if (txAbort) begin
          ctl.abortTake = 1'b1;
          stateD        = ST_RESTORE;
        end else if (txCommit) begin
          ctl.commitTake = 1'b1;
          stateD         = ST_IDLE;
        end
      end
      ST_RESTORE: begin
        if (restoreAck) begin
          ctl.restoreStep = 1'b1;
          if (idxLast) begin
            ctl.sleepLoad = 1'b1;
            stateD        = ST_SLEEP;
          end
        end
      end
      ST_SLEEP: begin
        if (sleepZero) stateD = ST_WAKE;
        else           ctl.sleepDec = 1'b1;
      end
      ST_WAKE: stateD = ST_RUN;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      retryQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      retryQ <= (stateQ == ST_WAKE);
    end
  end

  assign restoreReq = (stateQ == ST_RESTORE);
  assign lowPowerEn = (stateQ == ST_SLEEP);
  assign wakePulse  = (stateQ == ST_WAKE);
  assign retryStart = retryQ;

endmodule

// File: rtl/txBackoffPath.sv
module txBackoffPath
  import txBackoffPkg::*;
#(
  parameter int          WORDS   = 32,
  parameter int          LFSR_W  = 16,
  parameter logic [15:0] SEED    = 16'hACE1,
  parameter int          MAX_EXP = 10,
  parameter int          CNT_W   = 4,
  localparam int         IDX_W   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathCtl_t         ctl,
  output logic             idxLast,
  output logic             sleepZero,
  output logic [IDX_W-1:0] restoreIdx,
  output logic [CNT_W-1:0] abortCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [LFSR_W-1:0]  lfsrQ;
  logic [MAX_EXP-1:0] sleepQ;
  logic [MAX_EXP-1:0] winMask;
  logic               feedback;

  assign feedback = lfsrQ[15] ^ lfsrQ[13] ^ lfsrQ[12] ^ lfsrQ[10];

  // window mask: the low e bits set, e = min(count, MAX_EXP)
  always_comb begin
    for (int i = 0; i < MAX_EXP; i++)
      winMask[i] = (int'(abortCount) > i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ      <= SEED[LFSR_W-1:0];
      abortCount <= '0;
      restoreIdx <= '0;
      sleepQ     <= '0;
    end else begin
      if (ctl.abortTake) begin
        lfsrQ      <= {lfsrQ[LFSR_W-2:0], feedback};
        restoreIdx <= '0;
        if (abortCount != CNT_MAX) abortCount <= abortCount + 1'b1;
      end
      if (ctl.commitTake) abortCount <= '0;
      if (ctl.restoreStep) restoreIdx <= restoreIdx + 1'b1;
      if (ctl.sleepLoad)   sleepQ <= lfsrQ[MAX_EXP-1:0] & winMask;
      else if (ctl.sleepDec) sleepQ <= sleepQ - 1'b1;
    end
  end

  assign idxLast   = (restoreIdx == IDX_W'(WORDS - 1));
  assign sleepZero = (sleepQ == '0);

endmodule

// File: rtl/txBackoffTop.sv
module txBackoffTop
  import txBackoffPkg::*;
#(
  parameter int          WORDS   = 32,
  parameter int          LFSR_W  = 16,
  parameter logic [15:0] SEED    = 16'hACE1,
  parameter int          MAX_EXP = 10,
  parameter int          CNT_W   = 4,
  localparam int         IDX_W   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txBegin,
  input  logic             txCommit,
  input  logic             txAbort,
  input  logic             restoreAck,
  output logic             restoreReq,
  output logic [IDX_W-1:0] restoreIdx,
  output logic             lowPowerEn,
  output logic             wakePulse,
  output logic             retryStart,
  output logic [CNT_W-1:0] abortCount
);

  pathCtl_t ctl;
  logic     idxLast;
  logic     sleepZero;

  txBackoffCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txBegin    (txBegin),
    .txCommit   (txCommit),
    .txAbort    (txAbort),
    .restoreAck (restoreAck),
    .idxLast    (idxLast),
    .sleepZero  (sleepZero),
    .ctl        (ctl),
    .restoreReq (restoreReq),
    .lowPowerEn (lowPowerEn),
    .wakePulse  (wakePulse),
    .retryStart (retryStart)
  );

  txBackoffPath #(
    .WORDS   (WORDS),
    .LFSR_W  (LFSR_W),
    .SEED    (SEED),
    .MAX_EXP (MAX_EXP),
    .CNT_W   (CNT_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .idxLast    (idxLast),
    .sleepZero  (sleepZero),
    .restoreIdx (restoreIdx),
    .abortCount (abortCount)
  );

endmodule

// File: rtl/txBackoffChecker.sv
module txBackoffChecker #(
  parameter int IDX_W = 5,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             txCommit,
  input logic             txAbort,
  input logic             restoreAck,
  input logic             restoreReq,
  input logic [IDX_W-1:0] restoreIdx,
  input logic             lowPowerEn,
  input logic             wakePulse,
  input logic             retryStart,
  input logic [CNT_W-1:0] abortCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_restore_starts_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(restoreReq) |-> (restoreIdx == '0));

  assert_idx_holds_on_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (restoreReq && !restoreAck) |=> (restoreReq && $stable(restoreIdx)));

  assert_no_sleep_while_restoring_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(restoreReq && lowPowerEn));

  assert_wake_then_retry_R7: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> (retryStart && !wakePulse && !lowPowerEn));

  assert_sleep_abort_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lowPowerEn && txAbort) |=> (abortCount == $past(abortCount)));

  assert_count_saturates_R9: assert property (@(posedge clk) disable iff (!rstN)
    (abortCount == CNT_MAX && !txCommit) |=> (abortCount == CNT_MAX));

endmodule

bind txBackoffTop txBackoffChecker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/txBackoffTop_tb.sv
module txBackoffTop_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       txBegin, txCommit, txAbort, restoreAck;
  logic       restoreReq, lowPowerEn, wakePulse, retryStart;
  logic [4:0] restoreIdx;
  logic [3:0] abortCount;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  txBackoffTop u_dut (
    .clk(clk), .rstN(rstN), .txBegin(txBegin), .txCommit(txCommit),
    .txAbort(txAbort), .restoreAck(restoreAck), .restoreReq(restoreReq),
    .restoreIdx(restoreIdx), .lowPowerEn(lowPowerEn), .wakePulse(wakePulse),
    .retryStart(retryStart), .abortCount(abortCount)
  );

  // scenario vectors: bit0 = stall each word, bit1 = abort storm during
  // restore and sleep, bit2 = commit in the retry cycle
  localparam logic [2:0] SCEN [17] = '{
    3'b000, 3'b001, 3'b010, 3'b000, 3'b011, 3'b000, 3'b001, 3'b010,
    3'b000, 3'b000, 3'b010, 3'b001, 3'b000, 3'b000, 3'b010, 3'b000,
    3'b100
  };

  logic [15:0] lfsrModel = 16'hACE1;
  int          expCount  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic int expSleep();
    int e;
    e = (expCount > 10) ? 10 : expCount;
    return int'(lfsrModel[9:0] & 10'((1 << e) - 1)) + 1;
  endfunction

  // one abort from a running transaction through to the retry cycle
  task automatic runAbort(input bit stall, input bit storm, input bit commitAfter);
    int n;
    int want;
    txAbort = 1'b1;
    tick();
    txAbort = storm;
    lfsrModel = {lfsrModel[14:0], lfsrModel[15] ^ lfsrModel[13] ^ lfsrModel[12] ^ lfsrModel[10]};
    expCount  = (expCount < 15) ? expCount + 1 : 15;
    check(restoreReq && restoreIdx == 0 && !lowPowerEn, "R2", int'(restoreIdx), 0);
    check(abortCount == 4'(expCount), "R9", int'(abortCount), expCount);
    for (int w = 0; w < 32; w++) begin
      if (stall) begin
        restoreAck = 1'b0;
        tick();
        check(restoreReq && restoreIdx == 5'(w), "R3", int'(restoreIdx), w);
      end
      restoreAck = 1'b1;
      check(restoreIdx == 5'(w), "R3", int'(restoreIdx), w);
      tick();
    end
    restoreAck = 1'b0;
    check(lowPowerEn && !restoreReq, "R4", int'(lowPowerEn), 1);
    want = expSleep();
    n = 0;
    while (lowPowerEn && n < 2000) begin
      n++;
      tick();
    end
    check(n == want, "R6", n, want);
    check(wakePulse && !lowPowerEn, "R7", int'(wakePulse), 1);
    tick();
    txAbort = 1'b0;
    check(retryStart && !wakePulse, "R7", int'(retryStart), 1);
    check(abortCount == 4'(expCount), "R8", int'(abortCount), expCount);
    if (commitAfter) begin
      txCommit = 1'b1;
      tick();
      txCommit = 1'b0;
      expCount = 0;
      check(abortCount == 0, "R10", int'(abortCount), 0);
    end else begin
      tick();
      check(!retryStart && !restoreReq, "R7", int'(retryStart), 0);
    end
  endtask

  initial begin
    rstN = 1'b0; txBegin = 1'b0; txCommit = 1'b0; txAbort = 1'b0; restoreAck = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(!restoreReq && !lowPowerEn && !wakePulse && !retryStart &&
          abortCount == 0 && restoreIdx == 0, "R1", int'(abortCount), 0);
    rstN = 1'b1;
    tick();
    check(!restoreReq && !lowPowerEn && !retryStart, "R1", int'(restoreReq), 0);

    // abort while idle has no effect
    txAbort = 1'b1;
    tick();
    txAbort = 1'b0;
    tick();
    check(!restoreReq && abortCount == 0, "R8", int'(abortCount), 0);

    txBegin = 1'b1;
    tick();
    txBegin = 1'b0;
    check(!retryStart && !restoreReq, "R2", int'(retryStart), 0);

    // table walk: consecutive aborts, window growth, cap and saturation (R5 model)
    foreach (SCEN[i]) runAbort(SCEN[i][0], SCEN[i][1], SCEN[i][2]);

    // after commit: idle, so abort ignored until begin; window back to e = 1
    txAbort = 1'b1;
    tick();
    txAbort = 1'b0;
    check(!restoreReq && abortCount == 0, "R10", int'(restoreReq), 0);
    txBegin = 1'b1;
    tick();
    txBegin = 1'b0;
    runAbort(1'b0, 1'b0, 1'b0);
    check(abortCount == 1, "R10", int'(abortCount), 1);

    // commit from a running transaction clears count at 1
    txCommit = 1'b1;
    tick();
    txCommit = 1'b0;
    check(abortCount == 0 && !restoreReq, "R10", int'(abortCount), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule